// File: doc/BRIEF.md
# Counter Compare Match Channel

This block is one channel of a programmable counter array, used as a software timer. A shared free-running timebase counter is presented to the channel together with a one-cycle enable that marks each increment of that counter. Software loads a compare value over an 8-bit register bus. When the comparator is armed and the timebase equals the compare value on an increment cycle, the channel sets a sticky match flag. An interrupt request follows the flag while interrupts are enabled for the channel. The flag stays set until software writes it.

The compare value is wider than the bus, so software loads it in two byte writes. A write to the low byte disarms the comparator and a write to the high byte arms it again. Software writes the low byte first, so a 16-bit update cannot produce a false match while only half of the new value is in place. The mode, compare and status registers all read back on the same bus.

Top module: `pca_match_channel`

## Requirements
- R1: After reset the flag, the interrupt request, all mode bits and the compare value are 0, and every register reads back as 0x00.
- R2: When tbStep is 1, both the compare-enable (mode bit 2) and match-enable (mode bit 1) bits are 1, and tbCount equals the 16-bit compare value, the flag is 1 after that clock edge.
- R3: No match is detected when tbStep is 0, when either enable bit is 0, or when tbCount differs from the compare value in any bit. With no software write of 1 to the status register, the flag stays 0.
- R4: irq is 1 exactly when the flag is 1 and the interrupt-enable bit (mode bit 0) is 1.
- R5: Once set, the flag stays at 1 through any number of cycles, and through changes of mode, until a write to the status register (address 3) with data bit 0 equal to 0 clears it.
- R6: A write to the compare low byte (address 1) loads bits 7:0 of the compare value and forces the compare-enable bit to 0.
- R7: A write to the compare high byte (address 2) loads bits 15:8 of the compare value and forces the compare-enable bit to 1.
- R8: If a match and a software clear of the flag fall in the same cycle, the flag is 1 afterwards.
- R9: Readback is combinational on regAddr. Address 0 returns {5'b0, compareEnable, matchEnable, irqEnable}. Address 1 returns the compare low byte. Address 2 returns the compare high byte. Address 3 returns {7'b0, flag}. A write to address 0 sets all three mode bits from data bits 2:0.
- R10: Between a low-byte write and the following high-byte write, no timebase value raises the flag. This includes a value equal to the partly updated compare register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tbCount | input | 16 | Timebase counter value |
| tbStep | input | 1 | One-cycle pulse marking a timebase increment |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 mode, 1 compare low, 2 compare high, 3 status |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register readback for regAddr |
| flag | output | 1 | Sticky match flag |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check that the flag is set by a qualified match, that it rises for no other reason than a match or a software write, that it persists without a status write, that a match wins over a clear in the same cycle, and that the byte writes disarm and re-arm the comparator. Only the bench's scenarios can show the full readback encoding, the exact level of the interrupt under each mode, and the ordered low-then-high update sequence. That sequence includes timebase values equal to the half-updated compare value, which must stay silent.

// File: rtl/pca_match_pkg.sv
package pca_match_pkg;

  localparam int BUS_W = 8;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 2;

  localparam int MODE_IRQ_BIT   = 0;
  localparam int MODE_MATCH_BIT = 1;
  localparam int MODE_CMP_BIT   = 2;
  localparam int MODE_W         = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_MODE   = 2'd0,
    ADDR_CMPLO  = 2'd1,
    ADDR_CMPHI  = 2'd2,
    ADDR_STATUS = 2'd3
  } regAddrE;

  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic flagWr;
    logic flagWrVal;
    logic armed;
  } ctrlStrobeS;

endpackage

// File: rtl/pca_match_ctrl.sv
module pca_match_ctrl
  import pca_match_pkg::*;
#(
  parameter int BW = BUS_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [AW-1:0] regAddr,
  input  logic [BW-1:0] regWrData,
  output ctrlStrobeS    strobes,
  output logic [MODE_W-1:0] modeBits
);

  logic wrMode, wrLow, wrHigh, wrStatus;
  logic irqEnQ, matchEnQ, cmpEnQ;

  always_comb begin
    wrMode   = regWrEn && (regAddr == AW'(ADDR_MODE));
    wrLow    = regWrEn && (regAddr == AW'(ADDR_CMPLO));
    wrHigh   = regWrEn && (regAddr == AW'(ADDR_CMPHI));
    wrStatus = regWrEn && (regAddr == AW'(ADDR_STATUS));
  end

  // Mode register; byte writes to the compare register override the arm bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEnQ   <= 1'b0;
      matchEnQ <= 1'b0;
      cmpEnQ   <= 1'b0;
    end else begin
      if (wrMode) begin
        irqEnQ   <= regWrData[MODE_IRQ_BIT];
        matchEnQ <= regWrData[MODE_MATCH_BIT];
        cmpEnQ   <= regWrData[MODE_CMP_BIT];
      end else if (wrLow) begin
        cmpEnQ <= 1'b0;
      end else if (wrHigh) begin
        cmpEnQ <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes.loadLow   = wrLow;
    strobes.loadHigh  = wrHigh;
    strobes.flagWr    = wrStatus;
    strobes.flagWrVal = regWrData[0];
    strobes.armed     = cmpEnQ && matchEnQ;
    modeBits                 = '0;
    modeBits[MODE_IRQ_BIT]   = irqEnQ;
    modeBits[MODE_MATCH_BIT] = matchEnQ;
    modeBits[MODE_CMP_BIT]   = cmpEnQ;
  end

endmodule

// File: rtl/pca_match_datapath.sv
module pca_match_datapath
  import pca_match_pkg::*;
#(
  parameter int BW = BUS_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobeS    strobes,
  input  logic [BW-1:0] regWrData,
  input  logic [CW-1:0] tbCount,
  input  logic          tbStep,
  output logic [CW-1:0] cmpValue,
  output logic          flag
);

  localparam int HI_W = CW - BW;

  logic [BW-1:0]   cmpLowQ;
  logic [HI_W-1:0] cmpHighQ;
  logic            countEq;
  logic            matchEvent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpLowQ  <= '0;
      cmpHighQ <= '0;
    end else begin
      if (strobes.loadLow)  cmpLowQ  <= regWrData;
      if (strobes.loadHigh) cmpHighQ <= HI_W'(regWrData);
    end
  end

  assign cmpValue   = {cmpHighQ, cmpLowQ};
  assign countEq    = (tbCount == cmpValue);
  assign matchEvent = tbStep && strobes.armed && countEq;

  // Sticky flag: a match wins over a software write in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              flag <= 1'b0;
    else if (matchEvent)    flag <= 1'b1;
    else if (strobes.flagWr) flag <= strobes.flagWrVal;
  end

endmodule

// File: rtl/pca_match_channel.sv
module pca_match_channel
  import pca_match_pkg::*;
#(
  parameter int BW = BUS_W,
  parameter int CW = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] tbCount,
  input  logic          tbStep,
  input  logic          regWrEn,
  input  logic [AW-1:0] regAddr,
  input  logic [BW-1:0] regWrData,
  output logic [BW-1:0] regRdData,
  output logic          flag,
  output logic          irq
);

  ctrlStrobeS        strobes;
  logic [MODE_W-1:0] modeBits;
  logic [CW-1:0]     cmpValue;

  pca_match_ctrl #(.BW(BW), .AW(AW)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strobes(strobes), .modeBits(modeBits)
  );

  pca_match_datapath #(.BW(BW), .CW(CW)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWrData(regWrData),
    .tbCount(tbCount), .tbStep(tbStep), .cmpValue(cmpValue), .flag(flag)
  );

  assign irq = flag && modeBits[MODE_IRQ_BIT];

  always_comb begin
    regRdData = '0;
    case (regAddr)
      AW'(ADDR_MODE):   regRdData = BW'(modeBits);
      AW'(ADDR_CMPLO):  regRdData = cmpValue[BW-1:0];
      AW'(ADDR_CMPHI):  regRdData = BW'(cmpValue[CW-1:BW]);
      default:          regRdData = BW'(flag);
    endcase
  end

endmodule

// File: rtl/pca_match_checker.sv
module pca_match_checker #(
  parameter int BW = 8,
  parameter int CW = 16,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic [CW-1:0] tbCount,
  input logic          tbStep,
  input logic          regWrEn,
  input logic [AW-1:0] regAddr,
  input logic [BW-1:0] regWrData,
  input logic          flag,
  input logic          irq,
  input logic [2:0]    modeBits,
  input logic [CW-1:0] cmpValue
);

  logic hit, statusWr;
  assign hit      = tbStep && modeBits[2] && modeBits[1] && (tbCount == cmpValue);
  assign statusWr = regWrEn && (regAddr == AW'(3));

  assert_match_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> flag);

  assert_no_false_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!flag && !hit && !(statusWr && regWrData[0])) |=> !flag);

  assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> flag);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !statusWr) |=> flag);

  assert_low_disarms_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == AW'(1)) |=> (!modeBits[2] && cmpValue[BW-1:0] == $past(regWrData)));

  assert_high_arms_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == AW'(2)) |=> modeBits[2]);

  assert_match_beats_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hit && statusWr && !regWrData[0]) |=> flag);

endmodule

bind pca_match_channel pca_match_checker #(.BW(BW), .CW(CW), .AW(AW)) chk_i (
  .clk(clk), .rstN(rstN), .tbCount(tbCount), .tbStep(tbStep),
  .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .flag(flag), .irq(irq), .modeBits(modeBits), .cmpValue(cmpValue)
);

// File: tb/pca_match_channel_tb_top.sv
module pca_match_channel_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] tbCount = '0;
  logic        tbStep = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        flag, irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Independent reference state
  logic [15:0] mCmp;
  logic [2:0]  mMode;
  logic        mFlag;

  always #4 clk = ~clk;

  pca_match_channel dut_i (
    .clk(clk), .rstN(rstN), .tbCount(tbCount), .tbStep(tbStep),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .flag(flag), .irq(irq)
  );

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return {5'b0, mMode};
      2'd1: return mCmp[7:0];
      2'd2: return mCmp[15:8];
      default: return {7'b0, mFlag};
    endcase
  endfunction

  function automatic logic expIrq();
    return mFlag && mMode[0];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, check after it
  task automatic cycle(input logic step, input logic [15:0] cnt,
                       input logic we, input logic [1:0] a, input logic [7:0] d,
                       input string req);
    logic hit;
    @(negedge clk);
    tbStep = step; tbCount = cnt; regWrEn = we; regAddr = a; regWrData = d;
    @(posedge clk);
    hit = step && mMode[2] && mMode[1] && (cnt == mCmp);
    if (we && a == 2'd0) mMode = d[2:0];
    if (we && a == 2'd1) begin mCmp[7:0] = d; mMode[2] = 1'b0; end
    if (we && a == 2'd2) begin mCmp[15:8] = d; mMode[2] = 1'b1; end
    if (hit) mFlag = 1'b1;
    else if (we && a == 2'd3) mFlag = d[0];
    #1;
    check({req, " flag"}, 16'(flag), 16'(mFlag));
    check({req, " irq"}, 16'(irq), 16'(expIrq()));
    check({req, " read"}, 16'(regRdData), 16'(expRead(a)));
  endtask

  task automatic idle(input string req);
    cycle(1'b0, 16'h0, 1'b0, 2'd3, 8'h0, req);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    mCmp = '0; mMode = '0; mFlag = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 flag", 16'(flag), 16'h0);
    check("R1 irq", 16'(irq), 16'h0);
    for (int a = 0; a < 4; a++) begin
      regAddr = 2'(a); #1;
      check("R1 R9 reset read", 16'(regRdData), 16'h0);
    end
    @(negedge clk); rstN = 1'b1;

    // R9 mode write, R6/R7 arming via byte writes
    cycle(0, 16'h0, 1, 2'd0, 8'h03, "R9 mode");
    cycle(0, 16'h0, 1, 2'd1, 8'h34, "R6 low");
    cycle(0, 16'h0, 0, 2'd0, 8'h00, "R6 mode after low");
    cycle(0, 16'h0, 1, 2'd2, 8'h12, "R7 high");
    cycle(0, 16'h0, 0, 2'd0, 8'h00, "R7 mode after high");
    cycle(0, 16'h0, 0, 2'd1, 8'h00, "R9 low");
    cycle(0, 16'h0, 0, 2'd2, 8'h00, "R9 high");

    // R3 held counter, one-bit mismatch; R2 match; R4 irq
    cycle(0, 16'h1234, 0, 2'd3, 8'h0, "R3 no step");
    cycle(1, 16'h1235, 0, 2'd3, 8'h0, "R3 mismatch");
    cycle(1, 16'h9234, 0, 2'd3, 8'h0, "R3 high mismatch");
    cycle(1, 16'h1234, 0, 2'd3, 8'h0, "R2 R4 match");
    check("R4 irq level", 16'(irq), 16'h1);

    // R5 sticky across idle and mode change
    repeat (5) idle("R5 hold");
    cycle(0, 16'h0, 1, 2'd0, 8'h06, "R4 irq disabled");
    check("R4 irq off", 16'(irq), 16'h0);
    check("R5 still set", 16'(flag), 16'h1);
    cycle(0, 16'h0, 1, 2'd3, 8'h00, "R5 clear");

    // R10 partial update stays silent
    cycle(0, 16'h0, 1, 2'd1, 8'h00, "R10 low first");
    cycle(1, 16'h1200, 0, 2'd3, 8'h0, "R10 partial value");
    cycle(1, 16'h1234, 0, 2'd3, 8'h0, "R10 old value");
    check("R10 silent", 16'(flag), 16'h0);
    cycle(0, 16'h0, 1, 2'd2, 8'h56, "R10 high second");
    cycle(1, 16'h5600, 0, 2'd3, 8'h0, "R10 R2 new match");
    check("R10 matched", 16'(flag), 16'h1);

    // R8 match and clear together
    cycle(1, 16'h5600, 1, 2'd3, 8'h00, "R8 collide");
    check("R8 flag kept", 16'(flag), 16'h1);
    cycle(0, 16'h0, 1, 2'd3, 8'h00, "R5 clear again");

    // R3 match-enable off
    cycle(0, 16'h0, 1, 2'd0, 8'h05, "R3 mode cmp only");
    cycle(1, 16'h5600, 0, 2'd3, 8'h0, "R3 match disabled");
    check("R3 no flag", 16'(flag), 16'h0);
    cycle(0, 16'h0, 1, 2'd0, 8'h03, "R3 mode match only");
    cycle(1, 16'h5600, 0, 2'd3, 8'h0, "R3 cmp disabled");

    // Random traffic, counts biased toward the compare value
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] c;
      logic        we;
      logic [1:0]  a;
      logic [7:0]  d;
      int sel;
      sel = $urandom % 4;
      c = (sel == 0) ? 16'($urandom) : (sel == 1) ? mCmp ^ (16'h1 << ($urandom % 16)) : mCmp;
      we = ($urandom % 4) == 0;
      a = 2'($urandom);
      d = 8'($urandom);
      if (we && a == 2'd0) d[2:1] = 2'b11 & 2'($urandom | 1);
      cycle(1'($urandom), c, we, a, d, "R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule